// File: doc/BRIEF.md
# Serial Flash Reset Sequencer

This block is the device-side controller that decides when a serial memory is in reset. It watches an active-low external reset pin, a pulse from the command decoder that flags a decoded software reset command, and a flag saying whether the last power-on sequence completed properly. From these it drives four outputs: an ignore flag that makes the command decoder drop every read and write, an output-driver enable that puts the data pins into high impedance, a one-cycle pulse that clears the register file, and a standby indication.

The pin first passes through a two-flop synchronizer. A low level counts as a hardware reset only once it has lasted a minimum number of cycles, so glitches have no effect. A qualified reset can take one of two paths. If the previous power-up succeeded, the block runs a warm reset, which is a short blocked window. If it did not, the block runs the full power-up interval again. The pin is not watched while the power-up interval runs. If the pin is still low when any reset window closes, the block stays blocked until the pin is released. All durations are parameters counted in clock cycles.

Top module: `flash_rst_ctrl`

## Requirements
- R1: The reset pin is sampled through two flops. A low level qualifies as a hardware reset only after T_RP consecutive synchronized low samples. A shorter low pulse changes no output, and it restarts the width count, so two short pulses never add up to a qualified one.
- R2: When a reset qualifies, blocked_o goes to 1, out_en_o goes to 0 and reg_clr_o is high for exactly one cycle.
- R3: With por_ok_i = 1, a qualified reset keeps blocked_o high for T_RPH cycles. After that, if the pin is high, the block returns to ready.
- R4: With por_ok_i = 0, a qualified reset instead starts the full power-up interval of T_PU cycles.
- R5: When rst_ni is released, the block runs the power-up interval of T_PU cycles with blocked_o = 1. A low on the reset pin during this interval is ignored and produces no reg_clr_o pulse.
- R6: If the synchronized pin is low when the power-up interval ends, blocked_o stays 1 until the pin goes high.
- R7: If the synchronized pin is low when the warm reset window ends, blocked_o stays 1 until the pin goes high.
- R8: A sw_rst_i pulse in ready with the synchronized pin high produces one reg_clr_o pulse and a blocked window of T_SWR cycles. A sw_rst_i pulse while the synchronized pin is low is ignored.
- R9: out_en_o is 1 only in ready with cs_ni = 0. standby_o is 1 only in ready with cs_ni = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_ni | input | 1 | External hardware reset pin, active low, asynchronous to clk_i |
| cs_ni | input | 1 | Chip select, active low |
| sw_rst_i | input | 1 | One-cycle pulse: software reset command decoded |
| por_ok_i | input | 1 | 1 when the earlier power-on sequence completed correctly |
| blocked_o | output | 1 | Command decoder must ignore all reads and writes |
| out_en_o | output | 1 | Output drivers enabled; 0 means high impedance |
| reg_clr_o | output | 1 | One-cycle register clear pulse |
| standby_o | output | 1 | Ready and deselected |

## Verification
The hardest case to reach is a reset window that closes while the pin is still low, either at the end of power-up or at the end of a warm reset. To get there, the stimulus holds the pin low well past the end of the window and only then releases it. It checks that the block stays blocked until release and becomes ready a few cycles afterwards. The pulse-width counter restart is exercised with two sub-threshold pulses separated by a short high gap; without the restart, their combined length would exceed T_RP. A software reset is issued during the second of these pulses to show that it is ignored while the pin is low.

// File: rtl/flash_rst_pkg.sv
package flash_rst_pkg;
  typedef enum logic [1:0] {
    ST_PWRUP = 2'd0,
    ST_WARM  = 2'd1,
    ST_HOLD  = 2'd2,
    ST_READY = 2'd3
  } rst_state_e;
endpackage

// File: rtl/flash_rst_sync.sv
module flash_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/flash_rst_width.sv
module flash_rst_width #(
  parameter int T_RP = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic low_i,
  output logic qual_o
);
  localparam int CW = $clog2(T_RP + 1);
  localparam logic [CW-1:0] LAST = CW'(T_RP - 1);

  logic [CW-1:0] cnt_q;
  logic          counting;

  assign counting = en_i & low_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!counting)               cnt_q <= '0;
    else if (cnt_q != LAST)           cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = counting & (cnt_q == LAST);
endmodule

// File: rtl/flash_rst_timer.sv
module flash_rst_timer #(
  parameter int TW      = 8,
  parameter int RST_VAL = 100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= TW'(RST_VAL);
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/flash_rst_ctrl.sv
module flash_rst_ctrl
  import flash_rst_pkg::*;
#(
  parameter int T_RP  = 10,
  parameter int T_RPH = 1750,
  parameter int T_PU  = 15000,
  parameter int T_SWR = 1750
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_pin_ni,
  input  logic cs_ni,
  input  logic sw_rst_i,
  input  logic por_ok_i,
  output logic blocked_o,
  output logic out_en_o,
  output logic reg_clr_o,
  output logic standby_o
);
  localparam int MAX_A = (T_RPH > T_SWR) ? T_RPH : T_SWR;
  localparam int MAX_T = (T_PU > MAX_A) ? T_PU : MAX_A;
  localparam int TW    = $clog2(MAX_T + 1);

  rst_state_e    state_q, state_d;
  logic          pin_s;
  logic          qual;
  logic          tmr_done;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          clr_d, clr_q;
  logic          ready;

  assign ready = (state_q == ST_READY);

  flash_rst_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rst_pin_ni),
    .q_o   (pin_s)
  );

  flash_rst_width #(.T_RP(T_RP)) u_width (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ready),
    .low_i (!pin_s),
    .qual_o(qual)
  );

  flash_rst_timer #(.TW(TW), .RST_VAL(T_PU)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .done_o    (tmr_done)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = TW'(T_RPH);
    clr_d    = 1'b0;
    unique case (state_q)
      ST_PWRUP, ST_WARM: begin
        // window closed: hold while pin still low
        if (tmr_done) state_d = pin_s ? ST_READY : ST_HOLD;
      end
      ST_HOLD: begin
        if (pin_s) state_d = ST_READY;
      end
      ST_READY: begin
        if (qual) begin
          clr_d    = 1'b1;
          tmr_load = 1'b1;
          if (por_ok_i) begin
            tmr_val = TW'(T_RPH);
            state_d = ST_WARM;
          end else begin
            tmr_val = TW'(T_PU);
            state_d = ST_PWRUP;
          end
        end else if (sw_rst_i && pin_s) begin
          clr_d    = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TW'(T_SWR);
          state_d  = ST_WARM;
        end
      end
      default: state_d = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PWRUP;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      clr_q   <= clr_d;
    end
  end

  assign blocked_o = !ready;
  assign out_en_o  = ready & !cs_ni;
  assign standby_o = ready & cs_ni;
  assign reg_clr_o = clr_q;
endmodule

// File: rtl/flash_rst_ctrl_chk.sv
module flash_rst_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rst_pin_ni,
  input logic blocked_o,
  input logic out_en_o,
  input logic reg_clr_o,
  input logic standby_o
);
  p_clr_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_clr_o |=> !reg_clr_o);

  p_clr_blocks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_clr_o |-> blocked_o);

  p_clr_from_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_clr_o |-> !$past(blocked_o));

  p_hiz_blocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked_o |-> (!out_en_o && !standby_o));

  p_ready_one_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blocked_o |-> $onehot({out_en_o, standby_o}));

  // leaving reset needs the pin high three samples back (two sync flops + state)
  p_release_pin_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(blocked_o) |-> $past(rst_pin_ni, 3));
endmodule

bind flash_rst_ctrl flash_rst_ctrl_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rst_pin_ni(rst_pin_ni),
  .blocked_o (blocked_o),
  .out_en_o  (out_en_o),
  .reg_clr_o (reg_clr_o),
  .standby_o (standby_o)
);

// File: tb/flash_rst_ctrl_tb_top.sv
module flash_rst_ctrl_tb_top;
  localparam int T_RP  = 10;
  localparam int T_RPH = 100;
  localparam int T_PU  = 200;
  localparam int T_SWR = 40;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rst_pin_ni = 1'b1;
  logic cs_ni = 1'b1;
  logic sw_rst_i = 1'b0;
  logic por_ok_i = 1'b1;
  logic blocked_o, out_en_o, reg_clr_o, standby_o;

  int tests = 0;
  int fails = 0;
  int clr_cnt = 0;

  always #10 clk = ~clk;

  flash_rst_ctrl #(.T_RP(T_RP), .T_RPH(T_RPH), .T_PU(T_PU), .T_SWR(T_SWR)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .rst_pin_ni(rst_pin_ni),
    .cs_ni     (cs_ni),
    .sw_rst_i  (sw_rst_i),
    .por_ok_i  (por_ok_i),
    .blocked_o (blocked_o),
    .out_en_o  (out_en_o),
    .reg_clr_o (reg_clr_o),
    .standby_o (standby_o)
  );

  always @(posedge clk) if (reg_clr_o) clr_cnt <= clr_cnt + 1;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_powerup();
    cyc(3);
    check("R5", "blocked in reset", blocked_o, 1);
    check("R9", "out_en in reset", out_en_o, 0);
    rst_ni = 1'b1;
    cyc(20);
    rst_pin_ni = 1'b0;           // long low during power-up: ignored
    cyc(T_RP + 10);
    rst_pin_ni = 1'b1;
    cyc(T_PU - T_RP - 40);
    check("R5", "blocked before tPU end", blocked_o, 1);
    cyc(20);
    check("R5", "ready after tPU", blocked_o, 0);
    check("R5", "no clear from pin during tPU", clr_cnt, 0);
    check("R9", "standby when deselected", standby_o, 1);
  endtask

  task automatic t_cs();
    cs_ni = 1'b0;
    cyc(2);
    check("R9", "out_en selected", out_en_o, 1);
    check("R9", "standby selected", standby_o, 0);
    cs_ni = 1'b1;
    cyc(2);
    check("R9", "out_en deselected", out_en_o, 0);
  endtask

  task automatic t_short();
    int c0 = clr_cnt;
    rst_pin_ni = 1'b0;
    cyc(T_RP - 3);
    rst_pin_ni = 1'b1;
    cyc(2);
    rst_pin_ni = 1'b0;
    cyc(5);
    sw_rst_i = 1'b1;             // pin low: software reset ignored
    cyc(1);
    sw_rst_i = 1'b0;
    cyc(T_RP - 9);
    rst_pin_ni = 1'b1;
    cyc(10);
    check("R1", "short pulses not qualified", blocked_o, 0);
    check("R8", "sw reset ignored with pin low", clr_cnt - c0, 0);
  endtask

  task automatic t_warm();
    int c0 = clr_cnt;
    cs_ni = 1'b0;
    rst_pin_ni = 1'b0;
    cyc(T_RP + 5);
    rst_pin_ni = 1'b1;
    cyc(3);
    check("R2", "blocked after qualify", blocked_o, 1);
    check("R2", "hi-Z after qualify", out_en_o, 0);
    check("R2", "one clear pulse", clr_cnt - c0, 1);
    cyc(T_RPH - 18);
    check("R3", "blocked inside tRPH", blocked_o, 1);
    cyc(25);
    check("R3", "ready after tRPH", blocked_o, 0);
    check("R9", "out_en back", out_en_o, 1);
    cs_ni = 1'b1;
  endtask

  task automatic t_por();
    int c0 = clr_cnt;
    por_ok_i = 1'b0;
    rst_pin_ni = 1'b0;
    cyc(T_RP + 5);
    rst_pin_ni = 1'b1;
    cyc(T_RPH + 10);
    check("R4", "still blocked past tRPH", blocked_o, 1);
    cyc(T_PU - T_RPH + 5);
    check("R4", "ready after tPU", blocked_o, 0);
    check("R4", "one clear pulse", clr_cnt - c0, 1);
    por_ok_i = 1'b1;
  endtask

  task automatic t_warm_hold();
    rst_pin_ni = 1'b0;
    cyc(T_RP + T_RPH + 30);
    check("R7", "held past tRPH with pin low", blocked_o, 1);
    rst_pin_ni = 1'b1;
    cyc(6);
    check("R7", "ready after pin release", blocked_o, 0);
  endtask

  task automatic t_pu_hold();
    rst_ni = 1'b0;
    rst_pin_ni = 1'b0;
    cyc(3);
    rst_ni = 1'b1;
    cyc(T_PU + 20);
    check("R6", "held past tPU with pin low", blocked_o, 1);
    rst_pin_ni = 1'b1;
    cyc(6);
    check("R6", "ready after pin release", blocked_o, 0);
  endtask

  task automatic t_sw();
    int c0 = clr_cnt;
    sw_rst_i = 1'b1;
    cyc(1);
    sw_rst_i = 1'b0;
    cyc(2);
    check("R8", "blocked after sw reset", blocked_o, 1);
    check("R8", "one clear pulse", clr_cnt - c0, 1);
    cyc(T_SWR - 12);
    check("R8", "blocked inside sw window", blocked_o, 1);
    cyc(20);
    check("R8", "ready after sw window", blocked_o, 0);
  endtask

  initial begin
    t_powerup();
    t_cs();
    t_short();
    t_warm();
    t_por();
    t_warm_hold();
    t_pu_hold();
    t_sw();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule